// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A test controller drives a test clock, a mode-select line and a serial data input. From these the block walks a sixteen-state control machine, keeps a three-bit instruction, and places one of three data registers between the serial input and the serial output. The three data registers are a one-bit pass-through register, a 32-bit identity word and a 109-bit boundary register. The boundary register is loaded from a parallel capture vector and drives a parallel update vector.

The controller states and their successors are listed below as (mode-select low / mode-select high):

| State | Low | High |
|---|---|---|
| RESET | IDLE | RESET |
| IDLE | IDLE | DR_SEL |
| DR_SEL | DR_CAP | IR_SEL |
| DR_CAP | DR_SHIFT | DR_EXIT1 |
| DR_SHIFT | DR_SHIFT | DR_EXIT1 |
| DR_EXIT1 | DR_PAUSE | DR_UPD |
| DR_PAUSE | DR_PAUSE | DR_EXIT2 |
| DR_EXIT2 | DR_SHIFT | DR_UPD |
| DR_UPD | IDLE | DR_SEL |
| IR_SEL | IR_CAP | RESET |
| IR_CAP | IR_SHIFT | IR_EXIT1 |
| IR_SHIFT | IR_SHIFT | IR_EXIT1 |
| IR_EXIT1 | IR_PAUSE | IR_UPD |
| IR_PAUSE | IR_PAUSE | IR_EXIT2 |
| IR_EXIT2 | IR_SHIFT | IR_UPD |
| IR_UPD | IDLE | DR_SEL |

Instruction codes are: identity 001, sample/preload 100, pass-through 111. Every other code selects the pass-through register. All registers shift least significant bit first. The serial input enters at the most significant end.

Top module: `tap_port`

## Requirements
- R1: On each rising edge of `tck`, the state advances as the table gives for the value of `tms`. A data or instruction scan may pass through its pause state and come back to shift without losing or repeating a bit.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to RESET from any state.
- R3: When `trst_n` is low, and on every edge spent in RESET, the instruction becomes the identity code 001.
- R4: With the identity instruction, the 32-bit identity word is captured in DR_CAP. Bits 31:29 hold the revision, bits 28:12 the device number, bits 11:1 the vendor code, and bit 0 is 1. The word is shifted out bit 0 first.
- R5: The instruction shift register is three bits wide. It loads 001 in IR_CAP and shifts in IR_SHIFT. Its content becomes the active instruction only in IR_UPD.
- R6: Code 111, and any code that is not 001 or 100, selects a one-bit register. This register captures 0, so each data scan returns 0 followed by the input delayed by one clock.
- R7: Under code 100, the 109-bit boundary register captures `pin_vec` in DR_CAP. The captured bits shift out while new bits shift in during the same scan. In DR_UPD the shifted content is copied to `bsr_out`.
- R8: `tdo` and `tdo_en` change only on falling edges of `tck`. `tdo_en` is high exactly while the state is IR_SHIFT or DR_SHIFT, and `tdo` is 0 whenever `tdo_en` is low.
- R9: `bsr_out` keeps its value through any scan made under an instruction other than 100, including that scan's DR_UPD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data input, sampled on rising `tck` |
| pin_vec | input | BSR_LEN | Parallel values captured into the boundary register |
| tdo | output | 1 | Serial data output, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` is driven; low means high impedance |
| bsr_out | output | BSR_LEN | Boundary update register |

## Verification
A wrong controller state shows up within one falling edge, because `tdo_en` rises or falls at the wrong time. A misplaced capture or shift shows in the first serial bit of the affected scan. A wrong active instruction changes the length and content of the next data scan, and a stray update changes `bsr_out` at the end of that scan. The bench keeps a behavioural model with queues for the shift paths and compares `tdo_en`, `tdo` and `bsr_out` on every clock. It also compares whole scans against values derived from the requirements.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1,
        ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1,
        ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_t;

    typedef enum logic [1:0] {
        DSEL_BYP, DSEL_ID, DSEL_BSR
    } dsel_t;

    function automatic dsel_t decode_ir(logic [IR_W-1:0] code);
        dsel_t s;
        case (code)
            OP_IDCODE: s = DSEL_ID;
            OP_SAMPLE: s = DSEL_BSR;
            default:   s = DSEL_BYP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       ir_cap,
    output logic       ir_shift,
    output logic       ir_upd,
    output logic       dr_cap,
    output logic       dr_shift,
    output logic       dr_upd
);

    tap_state_t nxt;

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // next-state decision on the sampled mode-select
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    // per-state action strobes
    always_comb begin
        in_reset = 1'b0;
        ir_cap   = 1'b0;
        ir_shift = 1'b0;
        ir_upd   = 1'b0;
        dr_cap   = 1'b0;
        dr_shift = 1'b0;
        dr_upd   = 1'b0;
        unique case (state)
            ST_RESET:    in_reset = 1'b1;
            ST_IR_CAP:   ir_cap   = 1'b1;
            ST_IR_SHIFT: ir_shift = 1'b1;
            ST_IR_UPD:   ir_upd   = 1'b1;
            ST_DR_CAP:   dr_cap   = 1'b1;
            ST_DR_SHIFT: dr_shift = 1'b1;
            ST_DR_UPD:   dr_upd   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/tap_ireg.sv
module tap_ireg
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            shift,
    input  logic            upd,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_cur,
    output logic            sout
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh  <= IR_CAPTURE;
            ir_cur <= OP_IDCODE;
        end else begin
            if (in_reset)  ir_cur <= OP_IDCODE;
            else if (upd)  ir_cur <= ir_sh;
            if (cap)        ir_sh <= IR_CAPTURE;
            else if (shift) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    assign sout = ir_sh[0];

endmodule

// File: rtl/tap_dreg.sv
module tap_dreg
    import tap_pkg::*;
#(
    parameter int              BSR_LEN = 109,
    parameter logic [ID_W-1:0] ID_WORD = 32'h1
) (
    input  logic               tck,
    input  logic               trst_n,
    input  dsel_t              sel,
    input  logic               cap,
    input  logic               shift,
    input  logic               upd,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_vec,
    output logic               sout,
    output logic [BSR_LEN-1:0] bsr_out
);

    localparam int BSR_MSB = BSR_LEN - 1;
    localparam int ID_MSB  = ID_W - 1;

    logic               byp_q;
    logic [ID_MSB:0]    id_sh;
    logic [BSR_MSB:0]   bsr_sh;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
            id_sh <= '0;
        end else begin
            if (sel == DSEL_BYP) begin
                if (cap)        byp_q <= 1'b0;
                else if (shift) byp_q <= tdi;
            end
            if (sel == DSEL_ID) begin
                if (cap)        id_sh <= ID_WORD;
                else if (shift) id_sh <= {tdi, id_sh[ID_MSB:1]};
            end
        end
    end

    // boundary path: shift stage and update stage
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            bsr_sh  <= '0;
            bsr_out <= '0;
        end else if (sel == DSEL_BSR) begin
            if (cap)        bsr_sh <= pin_vec;
            else if (shift) bsr_sh <= {tdi, bsr_sh[BSR_MSB:1]};
            if (upd)        bsr_out <= bsr_sh;
        end
    end

    always_comb begin
        unique case (sel)
            DSEL_ID:  sout = id_sh[0];
            DSEL_BSR: sout = bsr_sh[0];
            default:  sout = byp_q;
        endcase
    end

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 109,
    parameter logic [2:0]  ID_REV  = 3'b000,
    parameter logic [16:0] ID_DEV  = 17'h0A5C3,
    parameter logic [10:0] ID_VEN  = 11'h2B5
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_vec,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] bsr_out
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_DEV, ID_VEN, 1'b1};

    tap_state_t      state;
    logic            in_reset, ir_cap, ir_shift, ir_upd;
    logic            dr_cap, dr_shift, dr_upd;
    logic [IR_W-1:0] ir_cur;
    logic            ir_sout, dr_sout, sout, shifting;
    dsel_t           dsel;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .ir_cap(ir_cap), .ir_shift(ir_shift),
        .ir_upd(ir_upd), .dr_cap(dr_cap), .dr_shift(dr_shift),
        .dr_upd(dr_upd)
    );

    tap_ireg u_ireg (
        .tck(tck), .trst_n(trst_n), .in_reset(in_reset), .cap(ir_cap),
        .shift(ir_shift), .upd(ir_upd), .tdi(tdi), .ir_cur(ir_cur),
        .sout(ir_sout)
    );

    assign dsel = decode_ir(ir_cur);

    tap_dreg #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dreg (
        .tck(tck), .trst_n(trst_n), .sel(dsel), .cap(dr_cap),
        .shift(dr_shift), .upd(dr_upd), .tdi(tdi), .pin_vec(pin_vec),
        .sout(dr_sout), .bsr_out(bsr_out)
    );

    assign shifting = ir_shift | dr_shift;
    assign sout     = ir_shift ? ir_sout : dr_sout;

    // output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shifting;
            tdo    <= shifting ? sout : 1'b0;
        end
    end

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
#(
    parameter int BSR_LEN = 109
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tms,
    input logic               tdo,
    input logic               tdo_en,
    input logic [BSR_LEN-1:0] bsr_out,
    input tap_state_t         st,
    input logic [IR_W-1:0]    ir_cur
);

    logic [2:0] ones;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        ones <= '0;
        else if (!tms)      ones <= '0;
        else if (ones != 3'd5) ones <= ones + 3'd1;
    end

    p_idle_step_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ST_RESET && !tms) |=> (st == ST_IDLE));

    p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones == 3'd5) |-> (st == ST_RESET));

    p_reset_ir_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ST_RESET) |=> (ir_cur == OP_IDCODE));

    p_ir_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (st != ST_IR_UPD && st != ST_RESET) |=> $stable(ir_cur));

    p_oe_shift_r8: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (st == ST_IR_SHIFT || st == ST_DR_SHIFT));

    p_tdo_quiet_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo);

    p_bsr_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (st != ST_DR_UPD) |=> $stable(bsr_out));

endmodule

bind tap_port tap_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdo(tdo), .tdo_en(tdo_en),
    .bsr_out(bsr_out), .st(state), .ir_cur(ir_cur)
);

// File: tb/tap_port_tb.sv
module tap_port_tb;

    localparam int P   = 20;
    localparam int BL  = 109;
    localparam logic [2:0]  REV = 3'b000;
    localparam logic [16:0] DEV = 17'h0A5C3;
    localparam logic [10:0] VEN = 11'h2B5;
    localparam logic [31:0] IDW = {REV, DEV, VEN, 1'b1};

    // model state numbers
    localparam int S_RST = 0, S_IDL = 1, S_DSL = 2, S_DCP = 3, S_DSH = 4,
                   S_DX1 = 5, S_DPA = 6, S_DX2 = 7, S_DUP = 8, S_ISL = 9,
                   S_ICP = 10, S_ISH = 11, S_IX1 = 12, S_IPA = 13,
                   S_IX2 = 14, S_IUP = 15;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [BL-1:0] pin_vec;
    logic tdo, tdo_en;
    logic [BL-1:0] bsr_out;

    int checks = 0, errors = 0;
    bit done = 0;

    int rs;
    logic [2:0] rir;
    bit irq[$];
    bit drq[$];
    logic [BL-1:0] rbsr;

    tap_port #(.BSR_LEN(BL), .ID_REV(REV), .ID_DEV(DEV), .ID_VEN(VEN)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_vec(pin_vec),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_out(bsr_out)
    );

    always #(P/2) tck = ~tck;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic int nxt_state(int s, logic m);
        case (s)
            S_RST: return m ? S_RST : S_IDL;
            S_IDL: return m ? S_DSL : S_IDL;
            S_DSL: return m ? S_ISL : S_DCP;
            S_DCP, S_DSH: return m ? S_DX1 : S_DSH;
            S_DX1: return m ? S_DUP : S_DPA;
            S_DPA: return m ? S_DX2 : S_DPA;
            S_DX2: return m ? S_DUP : S_DSH;
            S_DUP, S_IUP: return m ? S_DSL : S_IDL;
            S_ISL: return m ? S_RST : S_ICP;
            S_ICP, S_ISH: return m ? S_IX1 : S_ISH;
            S_IX1: return m ? S_IUP : S_IPA;
            S_IPA: return m ? S_IX2 : S_IPA;
            S_IX2: return m ? S_IUP : S_ISH;
            default: return S_RST;
        endcase
    endfunction

    // 0 bypass, 1 identity, 2 boundary
    function automatic int which(logic [2:0] c);
        if (c == 3'b001) return 1;
        if (c == 3'b100) return 2;
        return 0;
    endfunction

    task automatic model_edge(logic m, logic d);
        case (rs)
            S_RST: rir = 3'b001;
            S_ICP: begin irq.delete(); irq.push_back(1); irq.push_back(0); irq.push_back(0); end
            S_ISH: begin void'(irq.pop_front()); irq.push_back(d); end
            S_IUP: rir = {irq[2], irq[1], irq[0]};
            S_DCP: begin
                drq.delete();
                if (which(rir) == 1) for (int i = 0; i < 32; i++) drq.push_back(IDW[i]);
                else if (which(rir) == 2) for (int i = 0; i < BL; i++) drq.push_back(pin_vec[i]);
                else drq.push_back(0);
            end
            S_DSH: begin void'(drq.pop_front()); drq.push_back(d); end
            S_DUP: if (which(rir) == 2) for (int i = 0; i < BL; i++) rbsr[i] = drq[i];
            default: ;
        endcase
        rs = nxt_state(rs, m);
    endtask

    // one TCK cycle with cycle-by-cycle comparison
    task automatic step(input logic m, input logic d);
        logic pre;
        bit en;
        tms = m; tdi = d;
        pre = tdo;
        @(posedge tck);
        model_edge(m, d);
        #1;
        chk(tdo == pre, "R8 tdo moved on rising edge", tdo, pre);
        @(negedge tck);
        #(P/4);
        en = (rs == S_ISH) || (rs == S_DSH);
        chk(tdo_en == en, "R1/R8 tdo_en vs state", tdo_en, en);
        if (rs == S_ISH)      chk(tdo == irq[0], "R5 ir serial out", tdo, irq[0]);
        else if (rs == S_DSH) chk(tdo == drq[0], "R4/R6/R7 dr serial out", tdo, drq[0]);
        else                  chk(tdo == 1'b0, "R8 tdo low when disabled", tdo, 0);
        chk(bsr_out == rbsr, "R7/R9 bsr_out vs model", bsr_out, rbsr);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        dout[0] = tdo;
        for (int i = 0; i < n; i++) begin
            step(logic'(i == n - 1), din[i]);
            if (i < n - 1) dout[i+1] = tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] dout);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        dout[0] = tdo;
        for (int i = 0; i < 3; i++) begin
            step(logic'(i == 2), code[i]);
            if (i < 2) dout[i+1] = tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #(P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [127:0] din, dout, exp;
        logic [2:0] iro;
        for (int i = 0; i < BL; i++) pin_vec[i] = ((i * 7 + 3) % 5) < 2;
        rs = S_RST; rir = 3'b001; rbsr = '0;
        repeat (3) @(posedge tck);
        @(negedge tck); #(P/4);
        chk(tdo_en == 1'b0, "R3 reset tdo_en", tdo_en, 0);
        chk(bsr_out == '0, "R3 reset bsr_out", bsr_out, 0);
        trst_n = 1'b1;
        step(0, 0);

        // R3/R4: identity word after reset
        scan_dr(32, '0, dout);
        chk(dout[31:0] == IDW, "R4 id word", dout[31:0], IDW);

        // R5: instruction capture pattern, load bypass
        scan_ir(3'b111, iro);
        chk(iro == 3'b001, "R5 ir capture", iro, 3'b001);

        // R6: bypass delays by one
        din = 128'hB2;
        scan_dr(8, din, dout);
        exp = {din[126:0], 1'b0};
        chk(dout[7:0] == exp[7:0], "R6 bypass 111", dout[7:0], exp[7:0]);

        // R6: unused code acts as bypass
        scan_ir(3'b010, iro);
        din = 128'h5C;
        scan_dr(8, din, dout);
        exp = {din[126:0], 1'b0};
        chk(dout[7:0] == exp[7:0], "R6 unused code", dout[7:0], exp[7:0]);

        // R7: sample/preload
        scan_ir(3'b100, iro);
        din = '0;
        for (int i = 0; i < BL; i++) din[i] = (i % 3 == 0);
        scan_dr(BL, din, dout);
        chk(dout[BL-1:0] == pin_vec, "R7 captured pins", dout[BL-1:0], pin_vec);
        chk(bsr_out == din[BL-1:0], "R7 preload update", bsr_out, din[BL-1:0]);
        for (int i = 0; i < BL; i++) din[i] = (i % 4 != 1);
        scan_dr(BL, din, dout);
        chk(dout[BL-1:0] == pin_vec, "R7 second capture", dout[BL-1:0], pin_vec);
        chk(bsr_out == din[BL-1:0], "R7 second update", bsr_out, din[BL-1:0]);
        exp = din;

        // R9: bypass scan leaves bsr_out alone
        scan_ir(3'b111, iro);
        scan_dr(8, 128'hFF, dout);
        chk(bsr_out == exp[BL-1:0], "R9 bsr_out held", bsr_out, exp[BL-1:0]);

        // R2: five ones from shift-DR
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        scan_dr(32, '0, dout);
        chk(dout[31:0] == IDW, "R2 five ones reset to identity", dout[31:0], IDW);
        chk(bsr_out == exp[BL-1:0], "R9 bsr_out after reset path", bsr_out, exp[BL-1:0]);

        // R1: pause inside a data scan
        step(1, 0); step(0, 0); step(0, 0);
        step(0, 0); step(0, 0); step(0, 0);
        step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
        chk(tdo == IDW[4], "R1 pause resumes at bit 4", tdo, IDW[4]);
        step(1, 0); step(1, 0); step(0, 0);

        report();
    end

endmodule